// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block sequences an integrating dual-slope analog-to-digital converter whose integrator, comparator, reference and capacitor sit outside it. After a start pulse it zeroes the integrator for a programmable number of clock ticks. It then integrates the unknown input over a fixed window and ramps the integrator back down from the reference. The number of ticks that the ramp-down takes is the conversion result.

The input window equals a programmable tick count per mains period times a programmable number of periods. This lets the window span a whole number of line cycles, so that line hum integrates to zero. With a 1 MHz clock, 20000 ticks times 5 periods gives 0.1 s, which is a whole number of cycles of both 50 Hz and 60 Hz. The only analog feedback is a comparator that reports the integrator back at its low threshold; no upper threshold exists. A programmable ceiling on the ramp-down count ends a conversion that never trips and flags it as overrange.

Top module: `dual_slope_ctrl`

## Requirements
- R1: After reset the block is idle: all three switch selects, busy, done, overrange and result are 0.
- R2: A start pulse sampled while idle begins a conversion. From the next cycle on, sel_zero is high for exactly max(az_ticks,1) cycles.
- R3: The input window (sel_signal high) lasts exactly period_ticks × period_count cycles, with each factor taken as at least 1. The window length does not depend on the comparator.
- R4: At most one of sel_zero, sel_signal and sel_ref is high in any cycle. Exactly one all-off cycle separates auto-zero from the input window, and exactly one separates the input window from the reference phase.
- R5: cmp_low passes through a two-flop synchronizer. The cycles of the reference phase are counted from 1. If cmp_low is first sampled high in cycle k of that phase, the reference phase lasts k+2 cycles and result is k. This holds whenever k ≤ deint_limit−1.
- R6: If the comparator has not been seen after the reference phase has run deint_limit+1 cycles, the conversion ends with result = deint_limit and overrange = 1. When a trip and the limit occur in the same cycle (k = deint_limit−1), the trip wins and overrange stays 0.
- R7: done is high for exactly the one cycle after the reference phase, with all selects off, and the block is idle in the next cycle. result and overrange hold their values until a later conversion ends. busy is high from the first auto-zero cycle through the done cycle.
- R8: A start pulse seen while busy, including in the done cycle, is ignored. The conversion in progress keeps its timing, and no new conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion when idle |
| cmp_low | input | 1 | Comparator: integrator has reached its low threshold (asynchronous) |
| az_ticks | input | CW | Auto-zero length in ticks |
| period_ticks | input | CW | Ticks per mains period |
| period_count | input | MW | Mains periods per input window |
| deint_limit | input | CW | Ceiling on the ramp-down count |
| sel_zero | output | 1 | Integrator switch: auto-zero position |
| sel_signal | output | 1 | Integrator switch: unknown input |
| sel_ref | output | 1 | Integrator switch: reference |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| overrange | output | 1 | Last conversion hit the ceiling |
| result | output | CW | Last conversion count |

## Verification
Two pairs of events can land in the same cycle. The synchronized comparator trip can coincide with the ramp-down counter reaching its ceiling, and a start pulse can coincide with the done strobe. The bench provokes the first by sweeping the trip cycle k across the ceiling, with k = deint_limit−1 as the colliding case, and it expects a normal result with no overrange there. It provokes the second by holding start high during the done cycle, and it judges that case at the ports: one cycle later busy and every select must be low.

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl #(
  parameter int CW = 20,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_low,
  input  logic [CW-1:0] az_ticks,
  input  logic [CW-1:0] period_ticks,
  input  logic [MW-1:0] period_count,
  input  logic [CW-1:0] deint_limit,
  output logic          sel_zero,
  output logic          sel_signal,
  output logic          sel_ref,
  output logic          busy,
  output logic          done,
  output logic          overrange,
  output logic [CW-1:0] result
);
  localparam int SYNC_LAT = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ZERO, S_GAP1, S_SIG, S_GAP2, S_REF, S_DONE
  } state_t;

  state_t              st;
  logic [CW-1:0]       cnt;
  logic [MW-1:0]       per;
  logic [SYNC_LAT-1:0] sync;

  wire cnt_last = ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, (st == S_ZERO) ? az_ticks : period_ticks};
  wire per_last = ({1'b0, per} + (MW+1)'(1)) >= {1'b0, period_count};
  wire tripped  = sync[SYNC_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      per       <= '0;
      sync      <= '0;
      result    <= '0;
      overrange <= 1'b0;
    end else begin
      sync <= {sync[SYNC_LAT-2:0], cmp_low};
      case (st)
        S_IDLE: if (start) begin
          st  <= S_ZERO;
          cnt <= '0;
        end
        S_ZERO: if (cnt_last) st <= S_GAP1;
                else cnt <= cnt + 1'b1;
        S_GAP1: begin
          st  <= S_SIG;
          cnt <= '0;
          per <= '0;
        end
        S_SIG: if (cnt_last) begin
          cnt <= '0;
          if (per_last) st <= S_GAP2;
          else per <= per + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_GAP2: begin
          st  <= S_REF;
          cnt <= '0;
        end
        S_REF: if (tripped) begin
          result    <= cnt - CW'(SYNC_LAT - 1);
          overrange <= 1'b0;
          st        <= S_DONE;
        end else if (cnt >= deint_limit) begin
          result    <= deint_limit;
          overrange <= 1'b1;
          st        <= S_DONE;
        end else cnt <= cnt + 1'b1;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel_zero   = (st == S_ZERO);
  assign sel_signal = (st == S_SIG);
  assign sel_ref    = (st == S_REF);
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
endmodule

// File: rtl/dual_slope_ctrl_chk.sv
module dual_slope_ctrl_chk #(
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_zero,
  input logic          sel_signal,
  input logic          sel_ref,
  input logic          busy,
  input logic          done,
  input logic          overrange,
  input logic [CW-1:0] result,
  input logic [CW-1:0] deint_limit
);
  logic [CW:0] ref_run;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_run <= '0;
    else        ref_run <= sel_ref ? ref_run + 1'b1 : '0;
  end

  p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_zero, sel_signal, sel_ref}));

  p_gap_after_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_zero |=> (sel_zero || (!sel_signal && !sel_ref)));

  p_gap_after_signal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_signal |=> (sel_signal || !sel_ref));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(sel_zero || sel_signal || sel_ref));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ref |=> ($stable(result) && $stable(overrange)));

  p_ref_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ref |-> (ref_run <= {1'b0, deint_limit}));

  p_ovr_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overrange) |-> (result == deint_limit));

  p_busy_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind dual_slope_ctrl dual_slope_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_zero(sel_zero), .sel_signal(sel_signal),
  .sel_ref(sel_ref), .busy(busy), .done(done), .overrange(overrange),
  .result(result), .deint_limit(deint_limit)
);

// File: tb/dual_slope_ctrl_bench.sv
module dual_slope_ctrl_bench;
  localparam int CW = 8;
  localparam int MW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, start = 0, cmp_low = 0;
  logic [CW-1:0] az_ticks = 1, period_ticks = 1, deint_limit = 10;
  logic [MW-1:0] period_count = 1;
  logic sel_zero, sel_signal, sel_ref, busy, done, overrange;
  logic [CW-1:0] result;

  int checks = 0, failures = 0;

  dual_slope_ctrl #(.CW(CW), .MW(MW)) u_dual_slope_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_low(cmp_low),
    .az_ticks(az_ticks), .period_ticks(period_ticks), .period_count(period_count),
    .deint_limit(deint_limit), .sel_zero(sel_zero), .sel_signal(sel_signal),
    .sel_ref(sel_ref), .busy(busy), .done(done), .overrange(overrange),
    .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int code_now();
    int n = int'(sel_zero) + int'(sel_signal) + int'(sel_ref);
    if (n > 1) return 4;
    if (sel_zero) return 1;
    if (sel_signal) return 2;
    if (sel_ref) return 3;
    return 0;
  endfunction

  // a, lt, m >= 1; mx >= 1; k = comparator trip cycle within reference phase
  task automatic convert(input int a, input int lt, input int m, input int k, input int mx);
    int w, r, d, exp_res, refs, bad_idx, bad_act, bad_exp;
    bit exp_ovr, seq_ok, done_ok, busy_ok;
    w = lt * m;
    if (k <= mx - 1) begin r = k + 2; exp_res = k;  exp_ovr = 0; end
    else             begin r = mx + 1; exp_res = mx; exp_ovr = 1; end
    d = a + 2 + w + r;
    az_ticks = CW'(a); period_ticks = CW'(lt); period_count = MW'(m); deint_limit = CW'(mx);
    cmp_low = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    refs = 0; seq_ok = 1; done_ok = 1; busy_ok = 1; bad_idx = -1; bad_act = 0; bad_exp = 0;
    for (int i = 0; i <= d; i++) begin
      int ec, ac;
      if (i < a) ec = 1;
      else if (i == a) ec = 0;
      else if (i < a + 1 + w) ec = 2;
      else if (i == a + 1 + w) ec = 0;
      else if (i < d) ec = 3;
      else ec = 0;
      ac = code_now();
      if (ac != ec && seq_ok) begin seq_ok = 0; bad_idx = i; bad_act = ac; bad_exp = ec; end
      if (done != (i == d)) done_ok = 0;
      if (!busy) busy_ok = 0;
      if (sel_ref) begin
        refs++;
        if (refs >= k) cmp_low = 1;
      end
      start = (i % 3 == 1) || (i == d);
      if (i < d) @(negedge clk);
    end
    check(seq_ok, "R2/R3/R4 phase sequence", bad_act, bad_exp);
    if (!seq_ok) $display("  at cycle %0d of a=%0d lt=%0d m=%0d", bad_idx, a, lt, m);
    check(done_ok, "R7 done timing", int'(done), 1);
    check(busy_ok, "R7 busy through conversion", 0, 1);
    check(result == CW'(exp_res), exp_ovr ? "R6 saturated result" : "R5 measured count",
          int'(result), exp_res);
    check(overrange == exp_ovr, "R6 overrange flag", int'(overrange), int'(exp_ovr));
    @(negedge clk);
    check(!busy && code_now() == 0, "R8 start in done cycle ignored", int'(busy), 0);
    start = 0;
    cmp_low = ~cmp_low;
    repeat (3) @(negedge clk);
    check(result == CW'(exp_res) && overrange == exp_ovr && !busy, "R7 result held in idle",
          int'(result), exp_res);
    cmp_low = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!sel_zero && !sel_signal && !sel_ref && !busy && !done && !overrange && result == 0,
          "R1 reset state", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && code_now() == 0, "R1 idle after reset", int'(busy), 0);
    // R2 R3: sweep phase lengths
    for (int a = 1; a <= 3; a++)
      for (int lt = 1; lt <= 3; lt++)
        for (int m = 1; m <= 3; m++)
          convert(a, lt, m, 3, 10);
    // R5 R6: sweep trip cycle across the ceiling, including the collision k = mx-1
    for (int mx = 1; mx <= 6; mx++)
      for (int k = 1; k <= mx + 2; k++)
        convert(2, 2, 2, k, mx);
    // larger window, long count
    convert(5, 7, 6, 40, 200);
    convert(1, 1, 1, 1, 255);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule